// File: doc/BRIEF.md
# Upper-Memory Shadow and SMRAM Router

This block sits in the host bridge and decides, for each access to the upper part of the first megabyte, whether the cycle is served by on-board DRAM (a shadow copy or the system-management RAM) or is passed to the external bus. It is purely combinational. It sees the access address, whether the access is a write, two shadow control bytes and one system-management enable bit. Exactly one of three flags comes back: serve internally, forward externally, or leave the cycle unclaimed.

Three windows are claimed. The system-management window (A0000h to BFFFFh) is either served internally or left unclaimed. The expansion-ROM area (C0000h to DFFFFh) is split into one 32 KB block and six 16 KB segments, and all of them sit behind a master gate. The system BIOS window (E0000h to FFFFFh) has its own read enable. Reads and writes are routed independently. A single write-protect bit sends writes to shadowed regions off-chip, so a shadow copy can be read from DRAM while the ROM stays the write target.

Top module: `shdw_region_decode`

## Requirements
- R1: An address in A0000h to BFFFFh with `smram_en` high routes internally, for both reads and writes.
- R2: An address in A0000h to BFFFFh with `smram_en` low, and any address below A0000h, is unclaimed (`route_none` high).
- R3: A read in E0000h to FFFFFh routes internally when `bios_ctl` bit 7 is 1 and externally when it is 0.
- R4: `bios_ctl` bit 6 is a write-protect. When it is 1, writes to the BIOS window and writes to an enabled expansion segment route externally. When it is 0, those writes route internally. BIOS-window writes follow this bit even when `bios_ctl` bit 7 is 0.
- R5: When `xrom_ctl` bit 0 (the master gate) is 0, every read and write in C0000h to DFFFFh routes externally, whatever the other `xrom_ctl` bits are.
- R6: `xrom_ctl` bit 1 enables C0000h to C7FFFh as one 32 KB block. That range is enabled only by this bit.
- R7: `xrom_ctl` bit n (n = 2 to 7) enables the 16 KB segment based at C0000h + n·4000h (C8000h, CC000h, D0000h, D4000h, D8000h, DC000h). A bit affects no other segment.
- R8: Inside C0000h to DFFFFh with the gate set, a read of an enabled segment routes internally. Reads and writes of a disabled segment route externally.
- R9: For every input combination exactly one of `route_int`, `route_ext` and `route_none` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_addr | input | ADDR_W (20) | Byte address of the access |
| is_write | input | 1 | 1 = write access, 0 = read access |
| xrom_ctl | input | 8 | Expansion-area control: bit 0 master gate, bit 1 C0000h 32 KB block, bits 2 to 7 16 KB segments |
| bios_ctl | input | 8 | BIOS-area control: bit 7 read shadow, bit 6 write-protect; other bits ignored |
| smram_en | input | 1 | Enables internal service of A0000h to BFFFFh |
| route_int | output | 1 | Access is served by internal DRAM |
| route_ext | output | 1 | Access is forwarded to the external bus |
| route_none | output | 1 | Access is not claimed by this block |

## Verification
The bench builds the block with its default 20-bit address and the fixed 16 KB segment granularity, so every expansion segment and both edges of each window can be addressed. The sweep puts one address in each 16 KB segment through every mix of master gate, own segment bit, write-protect and direction. Each segment's neighbours always carry the opposite enable, which exposes any enable that leaks into the wrong segment. Directed vectors cover the window edges, the BIOS write path with read shadowing off, and the SMRAM window.

// File: rtl/shdw_pkg.sv
// Package: shared types and address-map constants for the shadow router.
// Assumes the three claimed windows are each 128 KB and aligned, so the
// top three address bits identify them.
package shdw_pkg;

    // Window codes produced by the classifier.
    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_SMRAM = 2'd1,
        WIN_XROM  = 2'd2,
        WIN_BIOS  = 2'd3
    } win_e;

    // One-hot routing result.
    typedef struct packed {
        logic internal;
        logic external;
        logic unclaimed;
    } route_t;

    localparam int unsigned WIN_SEL_W = 3;      // bits picking a 128 KB window
    localparam int unsigned SEG_SEL_W = 3;      // bits picking a 16 KB segment
    localparam logic [2:0]  SEL_SMRAM = 3'b101; // A0000h-BFFFFh
    localparam logic [2:0]  SEL_XROM  = 3'b110; // C0000h-DFFFFh
    localparam logic [2:0]  SEL_BIOS  = 3'b111; // E0000h-FFFFFh
    localparam int unsigned SEG_N     = 1 << SEG_SEL_W;
    localparam int unsigned WIDE_SEGS = 2;      // low segments sharing one enable

endpackage

// File: rtl/shdw_window_classify.sv
// Module: maps the top address bits to a window code and a 16 KB segment
// index within that window. Assumes the caller passes only the top bits.
module shdw_window_classify
    import shdw_pkg::*;
(
    input  logic [WIN_SEL_W+SEG_SEL_W-1:0] addr_hi,
    output win_e                           win,
    output logic [SEG_SEL_W-1:0]           seg_idx
);

    localparam int unsigned HI_W = WIN_SEL_W + SEG_SEL_W;

    // Decode the window from the top three address bits.
    always_comb begin
        unique case (addr_hi[HI_W-1 -: WIN_SEL_W])
            SEL_SMRAM: win = WIN_SMRAM;
            SEL_XROM:  win = WIN_XROM;
            SEL_BIOS:  win = WIN_BIOS;
            default:   win = WIN_NONE;
        endcase
    end

    // The segment index is the next three bits down.
    assign seg_idx = addr_hi[SEG_SEL_W-1:0];

endmodule

// File: rtl/shdw_segment_select.sv
// Module: picks the enable bit for one expansion segment and applies the
// master gate. Assumes the low WIDE_SEGS segments share one enable bit
// (index 1) and that every other segment's bit sits at its own index.
module shdw_segment_select
    import shdw_pkg::*;
(
    input  logic [SEG_N-1:0]     xrom_ctl,
    input  logic [SEG_SEL_W-1:0] seg_idx,
    output logic                 seg_on
);

    logic [SEG_N-1:0] seg_en;

    // Build the per-segment enable vector, one entry per 16 KB segment.
    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        if (g < WIDE_SEGS) begin : g_wide
            assign seg_en[g] = xrom_ctl[WIDE_SEGS-1];
        end else begin : g_narrow
            assign seg_en[g] = xrom_ctl[g];
        end
    end

    // Apply the master gate to the selected segment's enable.
    assign seg_on = xrom_ctl[0] & seg_en[seg_idx];

endmodule

// File: rtl/shdw_route_pick.sv
// Module: turns the window, direction and enables into a one-hot route.
// Assumes seg_on already includes the expansion-area master gate.
module shdw_route_pick
    import shdw_pkg::*;
(
    input  win_e   win,
    input  logic   is_write,
    input  logic   seg_on,
    input  logic   bios_rd_en,
    input  logic   wr_protect,
    input  logic   smram_en,
    output route_t route
);

    localparam route_t R_INT = '{internal: 1'b1, external: 1'b0, unclaimed: 1'b0};
    localparam route_t R_EXT = '{internal: 1'b0, external: 1'b1, unclaimed: 1'b0};
    localparam route_t R_UNC = '{internal: 1'b0, external: 1'b0, unclaimed: 1'b1};

    // Choose the destination for each window and direction.
    always_comb begin
        unique case (win)
            WIN_SMRAM: route = smram_en ? R_INT : R_UNC;
            WIN_BIOS: begin
                if (is_write) route = wr_protect ? R_EXT : R_INT;
                else          route = bios_rd_en ? R_INT : R_EXT;
            end
            WIN_XROM: begin
                if (!seg_on)                     route = R_EXT;
                else if (is_write && wr_protect) route = R_EXT;
                else                             route = R_INT;
            end
            default:  route = R_UNC;
        endcase
    end

    // Check the SMRAM window and the enabled-segment read path.
    always_comb begin
        if (win == WIN_SMRAM && !smram_en) begin
            p_smram_off_r2: assert (route.unclaimed)
                else $error("SMRAM window claimed while disabled");
        end
        if (win == WIN_SMRAM && smram_en) begin
            p_smram_on_r1: assert (route.internal)
                else $error("SMRAM window not internal while enabled");
        end
        if (win == WIN_XROM && seg_on && !is_write) begin
            p_seg_read_r8: assert (route.internal)
                else $error("enabled segment read not internal");
        end
    end

endmodule

// File: rtl/shdw_region_decode.sv
// Module (top): upper-memory shadow and SMRAM router. It is purely
// combinational. Assumes the address is a byte address of ADDR_W bits
// whose top six bits select the window and the 16 KB segment.
module shdw_region_decode
    import shdw_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              is_write,
    input  logic [7:0]        xrom_ctl,
    input  logic [7:0]        bios_ctl,
    input  logic              smram_en,
    output logic              route_int,
    output logic              route_ext,
    output logic              route_none
);

    localparam int unsigned HI_W  = WIN_SEL_W + SEG_SEL_W;
    localparam int unsigned LO_W  = ADDR_W - HI_W;
    localparam int unsigned RD_EN = 7;
    localparam int unsigned WP    = 6;

    win_e                 win;
    logic [SEG_SEL_W-1:0] seg_idx;
    logic                 seg_on;
    route_t               route;
    logic                 unused_bits;

    // Bits inside a segment and the spare BIOS control bits do not take part.
    assign unused_bits = ^{mem_addr[LO_W-1:0], bios_ctl[5:0]};

    shdw_window_classify u_classify (
        .addr_hi (mem_addr[ADDR_W-1 -: HI_W]),
        .win     (win),
        .seg_idx (seg_idx)
    );

    shdw_segment_select u_segsel (
        .xrom_ctl (xrom_ctl),
        .seg_idx  (seg_idx),
        .seg_on   (seg_on)
    );

    shdw_route_pick u_pick (
        .win        (win),
        .is_write   (is_write),
        .seg_on     (seg_on),
        .bios_rd_en (bios_ctl[RD_EN]),
        .wr_protect (bios_ctl[WP]),
        .smram_en   (smram_en),
        .route      (route)
    );

    // Drive the three port flags from the packed route.
    assign route_int  = route.internal;
    assign route_ext  = route.external;
    assign route_none = route.unclaimed;

    // Check the port-level routing rules.
    always_comb begin
        p_one_route_r9: assert ($onehot({route_int, route_ext, route_none}))
            else $error("route flags not one-hot");
        if (mem_addr[ADDR_W-1 -: WIN_SEL_W] == SEL_XROM && !xrom_ctl[0]) begin
            p_gate_closed_r5: assert (route_ext)
                else $error("gated expansion access not external");
        end
        if (is_write && bios_ctl[WP] && mem_addr[ADDR_W-1 -: WIN_SEL_W] == SEL_BIOS) begin
            p_bios_wp_r4: assert (route_ext)
                else $error("protected BIOS write not external");
        end
        if (mem_addr[ADDR_W-1] == 1'b0) begin
            p_low_unclaimed_r2: assert (route_none)
                else $error("low address claimed");
        end
    end

endmodule

// File: tb/shdw_region_decode_bench.sv
module shdw_region_decode_bench;

    localparam int ADDR_W = 20;
    localparam logic [2:0] E_INT = 3'b100, E_EXT = 3'b010, E_UNC = 3'b001;

    // Vector: {addr[19:0], wr, xrom[7:0], bios[7:0], smram, expected{int,ext,unc}}
    localparam int NV = 14;
    localparam logic [40:0] VEC [NV] = '{
        {20'hA0000, 1'b0, 8'h00, 8'h00, 1'b1, E_INT},  // R1 read
        {20'hBFFFF, 1'b1, 8'h00, 8'h00, 1'b1, E_INT},  // R1 write
        {20'hBFFFF, 1'b1, 8'h00, 8'h00, 1'b0, E_UNC},  // R2 disabled
        {20'h9FFFF, 1'b0, 8'hFF, 8'hC0, 1'b1, E_UNC},  // R2 below window
        {20'hF0000, 1'b0, 8'h00, 8'h80, 1'b0, E_INT},  // R3 shadow read
        {20'hFFFFF, 1'b0, 8'h00, 8'h7F, 1'b0, E_EXT},  // R3 no shadow
        {20'hE0000, 1'b1, 8'h00, 8'h40, 1'b0, E_EXT},  // R4 protected
        {20'hE0000, 1'b1, 8'h00, 8'h00, 1'b0, E_INT},  // R4 rd-off, unprotected
        {20'hC4000, 1'b0, 8'h03, 8'h00, 1'b0, E_INT},  // R6 upper half of block
        {20'hC7FFF, 1'b0, 8'hFE, 8'h00, 1'b0, E_EXT},  // R5 gate closed
        {20'hCC000, 1'b1, 8'h09, 8'h40, 1'b0, E_EXT},  // R4 protected segment
        {20'hCFFFF, 1'b0, 8'h09, 8'h40, 1'b0, E_INT},  // R8 segment read
        {20'hDC000, 1'b0, 8'h81, 8'h00, 1'b0, E_INT},  // R7 top segment
        {20'hDBFFF, 1'b1, 8'h81, 8'h00, 1'b0, E_EXT}   // R7 neighbour off
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic              is_write = 1'b0;
    logic [7:0]        xrom_ctl = '0;
    logic [7:0]        bios_ctl = '0;
    logic              smram_en = 1'b0;
    logic              route_int, route_ext, route_none;
    int                n_run = 0;
    int                n_fail = 0;
    int                cycles = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    shdw_region_decode #(.ADDR_W(ADDR_W)) u_shdw_region_decode (
        .mem_addr   (mem_addr),
        .is_write   (is_write),
        .xrom_ctl   (xrom_ctl),
        .bios_ctl   (bios_ctl),
        .smram_en   (smram_en),
        .route_int  (route_int),
        .route_ext  (route_ext),
        .route_none (route_none)
    );

    // Reference routing computed from the requirements.
    function automatic logic [2:0] ref_route(input logic [19:0] a, input logic wr,
                                             input logic [7:0] x, input logic [7:0] b,
                                             input logic s);
        logic [2:0] idx;
        logic       en;
        idx = a[16:14];
        case (a[19:17])
            3'b101: return s ? E_INT : E_UNC;
            3'b111: return wr ? (b[6] ? E_EXT : E_INT) : (b[7] ? E_INT : E_EXT);
            3'b110: begin
                en = x[0] & ((idx < 3'd2) ? x[1] : x[idx]);
                if (!en) return E_EXT;
                return (wr && b[6]) ? E_EXT : E_INT;
            end
            default: return E_UNC;
        endcase
    endfunction

    task automatic apply_check(input logic [19:0] a, input logic wr, input logic [7:0] x,
                               input logic [7:0] b, input logic s, input logic [2:0] exp,
                               input string tag);
        mem_addr = a; is_write = wr; xrom_ctl = x; bios_ctl = b; smram_en = s;
        @(negedge clk);
        n_run++;
        if ({route_int, route_ext, route_none} !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0b x=%h b=%h s=%0b actual=%b expected=%b",
                     tag, a, wr, x, b, s, {route_int, route_ext, route_none}, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // All-zero configuration state: R2 R3 R4 R5 R9
        apply_check(20'hA0000, 1'b0, 8'h00, 8'h00, 1'b0, E_UNC, "R2 idle smram");
        apply_check(20'hC0000, 1'b0, 8'h00, 8'h00, 1'b0, E_EXT, "R5 idle xrom");
        apply_check(20'hF0000, 1'b0, 8'h00, 8'h00, 1'b0, E_EXT, "R3 idle bios read");
        apply_check(20'hF0000, 1'b1, 8'h00, 8'h00, 1'b0, E_INT, "R4 idle bios write");
        // Directed table
        for (int i = 0; i < NV; i++) begin
            apply_check(VEC[i][40:21], VEC[i][20], VEC[i][19:12], VEC[i][11:4],
                        VEC[i][3], VEC[i][2:0], "R1..R9 table");
        end
        // Sweep: R5 R6 R7 R8 R4 R9, with neighbours holding the opposite enable
        for (int seg = 0; seg < 8; seg++) begin
            for (int g = 0; g < 2; g++) begin
                for (int sb = 0; sb < 2; sb++) begin
                    for (int wp = 0; wp < 2; wp++) begin
                        for (int wr = 0; wr < 2; wr++) begin
                            logic [19:0] a;
                            logic [7:0]  x, b;
                            int          bn;
                            bn = (seg < 2) ? 1 : seg;
                            x  = (sb != 0) ? 8'(1 << bn) : (8'hFE & ~8'(1 << bn));
                            x[0] = g[0];
                            b  = {1'b0, wp[0], 6'h15};
                            a  = 20'hC0000 + 20'(seg * 20'h4000) + 20'h123;
                            apply_check(a, wr[0], x, b, 1'b0,
                                        ref_route(a, wr[0], x, b, 1'b0),
                                        "R5 R6 R7 R8 R4 sweep");
                        end
                    end
                end
            end
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule